// File: doc/BRIEF.md
# Byte EEPROM Access Controller

This block sits on a small CPU's I/O register bus and gives the processor byte-wide access to a 128-byte nonvolatile data store. The store is a separate address space. Software uses three registers: an address register, a data register and a control register. It selects a byte, then starts a read or a write by writing the control register. The block drives a hold output that freezes the CPU pipeline for a fixed number of cycles after each access starts. A read holds the CPU longer than a write.

A write cannot start from a single stray store. Software must first set an arming bit. The start bit only takes effect while that bit is still live, which is four cycles. After an accepted start, a self-timed engine copies the address and data into its own storage and counts a programmable number of cycles. It then commits the byte to the array. While the engine runs, software polls the busy bit, and it may also take a ready interrupt when the engine is idle. The array is modelled as an internal register file, and the write time is a parameter.

Top module: `ee_byte_ctrl`

## Requirements
- R1: `bus_sel` picks the register on the bus: 0 is address, 1 is data, 2 is control, and 3 reads as zero. A byte written through a write and read back later through a read returns the same value at every address from 0 to 127.
- R2: The address register keeps 7 bits. Bit 7 of its readback is always zero, whatever was written to it.
- R3: A read starts when software writes control bit 0 as 1 while no write is running. It raises `cpu_hold` from the next cycle for exactly 4 cycles. Control bit 0 reads 1 during those cycles and 0 after them. The data register holds the addressed byte by the time the hold drops.
- R4: An accepted write start raises `cpu_hold` from the next cycle for exactly 2 cycles.
- R5: Writing control bit 2 as 1 arms the write path. Bit 2 then reads 1 for exactly 4 cycles and clears by itself. A write of control bit 1 as 1 starts a write only when it lands in one of those 4 cycles. In any other cycle it does nothing: no hold, no busy, and no change to the array.
- R6: Control bit 1 reads 1 (busy) for exactly WR_CYCLES cycles from the cycle after the accepted start. After that, the byte is committed at the address and with the data that were held when the start was accepted.
- R7: While busy, writes to the address and data registers take effect and read back their new values. They do not change the byte being committed.
- R8: A read start issued while busy is ignored. No hold appears and the data register keeps its value.
- R9: Control bit 3 enables the ready interrupt. In the default level variant, `irq` equals bit 3 AND NOT busy. In the pulse variant, `irq` is a one-cycle pulse after each write completes, and only while bit 3 is set.
- R10: After reset the control and data registers read zero, and `cpu_hold` and `irq` are low. The address register's reset value is unspecified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | DATA_W | Register write data |
| bus_rdata | output | DATA_W | Readback of the selected register |
| cpu_hold | output | 1 | Freezes the CPU pipeline |
| irq | output | 1 | Ready interrupt |

## Verification
The bench builds the block with WR_CYCLES set to 20 and every other parameter at its default, which is 4-cycle read hold, 2-cycle write hold, a 4-cycle arm window and a level interrupt. The short write time lets one run cover many complete write/poll/read sequences. Those sequences include writes at the last address, a register change partway through a write, and arm gaps on both sides of the window edge. The hold and arm lengths stay at their defaults, so the exact cycle counts that software depends on are the ones measured.

// File: rtl/ee_pkg.sv
package ee_pkg;
   typedef enum logic [1:0] {
      SEL_ADDR = 2'd0,
      SEL_DATA = 2'd1,
      SEL_CTRL = 2'd2,
      SEL_NONE = 2'd3
   } ee_sel_e;

   // control register bit positions (software-visible)
   localparam int CB_RD  = 0;
   localparam int CB_WR  = 1;
   localparam int CB_ARM = 2;
   localparam int CB_IEN = 3;
   localparam int CB_NUM = 4;
endpackage

// File: rtl/ee_hold_timer.sv
// Down-counter that stays active for CNT_MAX cycles after start; clr wins.
module ee_hold_timer #(
   parameter int CNT_MAX = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic clr,
   output logic active
);
   localparam int W = $clog2(CNT_MAX + 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (start)
         cnt <= W'(CNT_MAX);
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign active = (cnt != '0);
endmodule

// File: rtl/ee_write_engine.sv
// Self-timed write: captures address/data at start, commits after WR_CYCLES.
module ee_write_engine #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int WR_CYCLES = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              busy,
   output logic              commit,
   output logic [ADDR_W-1:0] c_addr,
   output logic [DATA_W-1:0] c_data
);
   localparam int CW = $clog2(WR_CYCLES + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         c_addr <= '0;
         c_data <= '0;
      end else if (start && !busy) begin
         busy   <= 1'b1;
         cnt    <= CW'(WR_CYCLES);
         c_addr <= addr_in;
         c_data <= data_in;
      end else if (busy) begin
         if (cnt == CW'(1)) begin
            busy <= 1'b0;
            cnt  <= '0;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end

   assign commit = busy && (cnt == CW'(1));
endmodule

// File: rtl/ee_store.sv
// Byte array model of the nonvolatile store: synchronous write, async read.
module ee_store #(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we)
         mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/ee_byte_ctrl.sv
module ee_byte_ctrl
   import ee_pkg::*;
#(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int WR_CYCLES = 64,
   parameter int RD_HOLD   = 4,
   parameter int WR_HOLD   = 2,
   parameter int ARM_WIN   = 4,
   parameter bit IRQ_PULSE = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_sel,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              cpu_hold,
   output logic              irq
);
   localparam int PAD_A = DATA_W - ADDR_W;
   localparam int PAD_C = DATA_W - CB_NUM;

   // elaboration-time parameter checks
   if (ADDR_W >= DATA_W) begin : g_bad_aw
      $error("ADDR_W must leave at least one reserved bit below DATA_W");
   end
   if (DATA_W < CB_NUM) begin : g_bad_dw
      $error("DATA_W too narrow for the control register");
   end
   if (WR_CYCLES <= WR_HOLD) begin : g_bad_wc
      $error("WR_CYCLES must exceed WR_HOLD");
   end
   if (RD_HOLD < 1 || WR_HOLD < 1 || ARM_WIN < 1) begin : g_bad_hold
      $error("hold and arm lengths must be at least one cycle");
   end

   logic              ctrl_wr, addr_wr, data_wr;
   logic              rd_start, wr_start, arm_set;
   logic              rd_hold, wr_hold, arm_on;
   logic              wr_busy, commit;
   logic [ADDR_W-1:0] addr_q, c_addr;
   logic [DATA_W-1:0] data_q, c_data, store_rd;
   logic              ien_q;

   assign ctrl_wr = bus_we && (bus_sel == SEL_CTRL);
   assign addr_wr = bus_we && (bus_sel == SEL_ADDR);
   assign data_wr = bus_we && (bus_sel == SEL_DATA);

   // write start needs a live arm window; write start beats read start
   assign wr_start = ctrl_wr && bus_wdata[CB_WR] && arm_on && !wr_busy && !cpu_hold;
   assign rd_start = ctrl_wr && bus_wdata[CB_RD] && !wr_busy && !cpu_hold && !wr_start;
   assign arm_set  = ctrl_wr && bus_wdata[CB_ARM] && !wr_start;

   ee_hold_timer #(.CNT_MAX(ARM_WIN)) u_arm (
      .clk(clk), .rst_n(rst_n), .start(arm_set), .clr(wr_start), .active(arm_on)
   );

   ee_hold_timer #(.CNT_MAX(RD_HOLD)) u_rd_hold (
      .clk(clk), .rst_n(rst_n), .start(rd_start), .clr(1'b0), .active(rd_hold)
   );

   ee_hold_timer #(.CNT_MAX(WR_HOLD)) u_wr_hold (
      .clk(clk), .rst_n(rst_n), .start(wr_start), .clr(1'b0), .active(wr_hold)
   );

   assign cpu_hold = rd_hold | wr_hold;

   ee_write_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES)) u_eng (
      .clk(clk), .rst_n(rst_n), .start(wr_start),
      .addr_in(addr_q), .data_in(data_q),
      .busy(wr_busy), .commit(commit), .c_addr(c_addr), .c_data(c_data)
   );

   ee_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
      .clk(clk), .we(commit), .waddr(c_addr), .wdata(c_data),
      .raddr(addr_q), .rdata(store_rd)
   );

   // address register: reset value left unspecified
   always_ff @(posedge clk) begin
      if (addr_wr)
         addr_q <= bus_wdata[ADDR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q <= '0;
         ien_q  <= 1'b0;
      end else begin
         if (data_wr)
            data_q <= bus_wdata;
         else if (rd_start)
            data_q <= store_rd;
         if (ctrl_wr)
            ien_q <= bus_wdata[CB_IEN];
      end
   end

   always_comb begin
      unique case (bus_sel)
         SEL_ADDR: bus_rdata = {{PAD_A{1'b0}}, addr_q};
         SEL_DATA: bus_rdata = data_q;
         SEL_CTRL: bus_rdata = {{PAD_C{1'b0}}, ien_q, arm_on, wr_busy, rd_hold};
         default:  bus_rdata = '0;
      endcase
   end

   if (IRQ_PULSE) begin : g_irq_pulse
      logic busy_d, irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            busy_d <= 1'b0;
            irq_q  <= 1'b0;
         end else begin
            busy_d <= wr_busy;
            irq_q  <= ien_q && busy_d && !wr_busy;
         end
      end
      assign irq = irq_q;
   end else begin : g_irq_level
      assign irq = ien_q && !wr_busy;
   end
endmodule

// File: rtl/ee_byte_ctrl_chk.sv
module ee_byte_ctrl_chk #(
   parameter int ADDR_W    = 7,
   parameter int DATA_W    = 8,
   parameter int WR_CYCLES = 64,
   parameter int RD_HOLD   = 4,
   parameter int WR_HOLD   = 2,
   parameter int ARM_WIN   = 4,
   parameter bit IRQ_PULSE = 1'b0
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] bus_sel,
   input logic       bus_we,
   input logic       arm_bit,
   input logic       rdata_msb,
   input logic       cpu_hold,
   input logic       irq,
   input logic       rd_start,
   input logic       wr_start,
   input logic       wr_busy,
   input logic       ien_q
);
   int hold_exp;
   int arm_exp;
   int busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_exp <= 0;
         arm_exp  <= 0;
         busy_len <= 0;
      end else begin
         if (rd_start)            hold_exp <= RD_HOLD;
         else if (wr_start)       hold_exp <= WR_HOLD;
         else if (hold_exp != 0)  hold_exp <= hold_exp - 1;

         if (wr_start)                                   arm_exp <= 0;
         else if (bus_we && bus_sel == 2'd2 && arm_bit)  arm_exp <= ARM_WIN;
         else if (arm_exp != 0)                          arm_exp <= arm_exp - 1;

         if (wr_start)     busy_len <= 0;
         else if (wr_busy) busy_len <= busy_len + 1;
      end
   end

   assert_addr_msb_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel == 2'd0) |-> !rdata_msb);

   assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_start |=> cpu_hold);

   // R3 and R4: hold length follows the kind of access that started it
   assert_hold_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hold == (hold_exp != 0));

   assert_arm_guard_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |-> (arm_exp != 0));

   assert_busy_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_start |=> wr_busy);

   assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(wr_busy) |-> (busy_len == WR_CYCLES));

   assert_rd_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_busy |-> !rd_start);

   if (!IRQ_PULSE) begin : g_lvl
      assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq == (ien_q && !wr_busy));
   end else begin : g_pls
      assert_irq_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
         irq |=> !irq);
   end
endmodule

bind ee_byte_ctrl ee_byte_ctrl_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYCLES(WR_CYCLES), .RD_HOLD(RD_HOLD),
   .WR_HOLD(WR_HOLD), .ARM_WIN(ARM_WIN), .IRQ_PULSE(IRQ_PULSE)
) chk_i (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .arm_bit(bus_wdata[2]), .rdata_msb(bus_rdata[DATA_W-1]),
   .cpu_hold(cpu_hold), .irq(irq), .rd_start(rd_start), .wr_start(wr_start),
   .wr_busy(wr_busy), .ien_q(ien_q)
);

// File: tb/ee_byte_ctrl_tb_top.sv
module ee_byte_ctrl_tb_top;
   localparam int CLK_P  = 10;
   localparam int WR_CYC = 20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] bus_sel = 2'd0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       cpu_hold, irq;

   int  total = 0;
   int  bad = 0;
   bit  done = 1'b0;
   bit  ien_b = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   ee_byte_ctrl #(.WR_CYCLES(WR_CYC)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_hold(cpu_hold), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic bus_wr(input logic [1:0] s, input logic [7:0] d);
      bus_sel = s; bus_we = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = 8'h00;
   endtask

   task automatic rd_reg(input logic [1:0] s, output logic [7:0] v);
      bus_sel = s;
      #1;
      v = bus_rdata;
   endtask

   function automatic logic [7:0] cw(input logic [7:0] bits);
      return bits | {4'b0, ien_b, 3'b000};
   endfunction

   task automatic wait_idle();
      logic [7:0] v;
      for (int i = 0; i < 4 * WR_CYC; i++) begin
         rd_reg(2'd2, v);
         if (!v[1]) break;
         @(negedge clk);
      end
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] d);
      logic [7:0] v;
      int busy_n = 0, hold_n = 0, irq_n = 0;
      bus_wr(2'd0, {1'b0, a});
      bus_wr(2'd1, d);
      bus_wr(2'd2, cw(8'h04));
      bus_wr(2'd2, cw(8'h02));
      for (int i = 0; i < 4 * WR_CYC; i++) begin
         rd_reg(2'd2, v);
         if (!v[1]) break;
         busy_n++;
         if (cpu_hold) hold_n++;
         if (irq) irq_n++;
         @(negedge clk);
      end
      chk(busy_n == WR_CYC, "R6 busy length", busy_n, WR_CYC);
      chk(hold_n == 2, "R4 write hold length", hold_n, 2);
      chk(irq_n == 0, "R9 irq low while busy", irq_n, 0);
   endtask

   task automatic do_read(input logic [6:0] a, input logic [7:0] exp, input string req);
      logic [7:0] v;
      int hold_n = 0, rbit_n = 0;
      bus_wr(2'd0, {1'b0, a});
      bus_wr(2'd2, cw(8'h01));
      for (int i = 0; i < 8; i++) begin
         rd_reg(2'd2, v);
         if (cpu_hold) hold_n++;
         if (v[0]) rbit_n++;
         @(negedge clk);
      end
      chk(hold_n == 4, "R3 read hold length", hold_n, 4);
      chk(rbit_n == 4, "R3 read bit self clears", rbit_n, 4);
      rd_reg(2'd1, v);
      chk(v == exp, req, v, exp);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      rd_reg(2'd2, v); chk(v == 8'h00, "R10 control after reset", v, 0);
      rd_reg(2'd1, v); chk(v == 8'h00, "R10 data after reset", v, 0);
      chk(!cpu_hold, "R10 hold after reset", cpu_hold, 0);
      chk(!irq, "R10 irq after reset", irq, 0);
      rd_reg(2'd3, v); chk(v == 8'h00, "R1 unused select reads zero", v, 0);
   endtask

   task automatic t_addr_mask();
      logic [7:0] v;
      bus_wr(2'd0, 8'hFF); rd_reg(2'd0, v);
      chk(v == 8'h7F, "R2 address bit 7 reads zero", v, 8'h7F);
      bus_wr(2'd0, 8'h80); rd_reg(2'd0, v);
      chk(v == 8'h00, "R2 address bit 7 not stored", v, 0);
   endtask

   task automatic t_write_read();
      do_write(7'd3, 8'h5A);
      do_write(7'd127, 8'hC3);
      do_write(7'd0, 8'h01);
      do_read(7'd3, 8'h5A, "R1 readback addr 3");
      do_read(7'd127, 8'hC3, "R1 readback top addr");
      do_read(7'd0, 8'h01, "R1 readback addr 0");
   endtask

   // arm, idle for gap cycles, then try to start a write
   task automatic try_go(input int gap, input bit exp_ok, input logic [6:0] a,
                         input logic [7:0] d);
      logic [7:0] v;
      bus_wr(2'd0, {1'b0, a});
      bus_wr(2'd1, d);
      bus_wr(2'd2, cw(8'h04));
      repeat (gap) @(negedge clk);
      bus_wr(2'd2, cw(8'h02));
      rd_reg(2'd2, v);
      chk(v[1] == exp_ok, $sformatf("R5 start after gap %0d", gap), v[1], exp_ok);
      chk(cpu_hold == exp_ok, $sformatf("R5 hold after gap %0d", gap), cpu_hold, exp_ok);
      wait_idle();
   endtask

   task automatic t_arm();
      logic [7:0] v;
      int on_n = 0;
      bus_wr(2'd2, cw(8'h04));
      for (int i = 0; i < 6; i++) begin
         rd_reg(2'd2, v);
         if (v[2]) on_n++;
         @(negedge clk);
      end
      chk(on_n == 4, "R5 arm bit lasts four cycles", on_n, 4);
      do_write(7'd20, 8'h20);
      try_go(3, 1'b1, 7'd21, 8'h21);
      try_go(4, 1'b0, 7'd20, 8'hEE);
      try_go(9, 1'b0, 7'd20, 8'hDD);
      do_read(7'd21, 8'h21, "R5 last window cycle wrote");
      do_read(7'd20, 8'h20, "R5 late start left array unchanged");
      bus_wr(2'd0, 8'd20);
      bus_wr(2'd1, 8'h99);
      bus_wr(2'd2, cw(8'h02));
      rd_reg(2'd2, v);
      chk(!v[1], "R5 start without arm ignored", v[1], 0);
      do_read(7'd20, 8'h20, "R5 unarmed start left array unchanged");
   endtask

   task automatic t_shadow();
      logic [7:0] v;
      int hold_n = 0;
      do_write(7'd9, 8'h11);
      bus_wr(2'd0, 8'd5);
      bus_wr(2'd1, 8'hAA);
      bus_wr(2'd2, cw(8'h04));
      bus_wr(2'd2, cw(8'h02));
      repeat (3) @(negedge clk);
      bus_wr(2'd0, 8'd9);
      bus_wr(2'd1, 8'h33);
      rd_reg(2'd0, v); chk(v == 8'd9, "R7 address changes while busy", v, 9);
      rd_reg(2'd1, v); chk(v == 8'h33, "R7 data changes while busy", v, 8'h33);
      bus_wr(2'd2, cw(8'h01));
      for (int i = 0; i < 5; i++) begin
         if (cpu_hold) hold_n++;
         @(negedge clk);
      end
      chk(hold_n == 0, "R8 read while busy gives no hold", hold_n, 0);
      rd_reg(2'd1, v); chk(v == 8'h33, "R8 read while busy keeps data", v, 8'h33);
      rd_reg(2'd2, v); chk(v[1], "R8 write still busy", v[1], 1);
      wait_idle();
      do_read(7'd5, 8'hAA, "R7 committed captured byte");
      do_read(7'd9, 8'h11, "R7 new address untouched");
   endtask

   task automatic t_irq();
      ien_b = 1'b1;
      bus_wr(2'd2, cw(8'h00));
      chk(irq, "R9 irq high when enabled and idle", irq, 1);
      do_write(7'd64, 8'h64);
      chk(irq, "R9 irq back after write", irq, 1);
      ien_b = 1'b0;
      bus_wr(2'd2, cw(8'h00));
      chk(!irq, "R9 irq low when disabled", irq, 0);
      do_read(7'd64, 8'h64, "R1 readback addr 64");
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr_mask();
      t_write_read();
      t_arm();
      t_shadow();
      t_irq();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule